// File: doc/BRIEF.md
# Seconds-and-Tenths Stopwatch

This block measures elapsed time from 00.0 to 59.9 seconds. A single active-low push button starts and stops it: every new press flips the watch between running and stopped, just as the one button on a runner's stopwatch does. A separate clear input sets the count back to 00.0. The clear only takes effect while the watch is stopped, so a running measurement cannot be wiped by accident.

A prescaler on the system clock produces one tenths tick every `PRESCALE` cycles. The prescaler runs only while the watch is running. The tenths digit is held as a rotating one-hot word. Its wrap from the top bit back to bit 0 carries into a BCD seconds counter that runs from 0 to 59. The two seconds digits leave the block as active-high seven-segment patterns. The tenths digit leaves as the 10-bit one-hot word itself.

A small controller samples the button and decides between running and stopped. It drives the counting datapath through a two-bit strobe struct. Debouncing and display multiplexing are done outside the block.

Top module: `stopwatch`

## Requirements
- R1: A synchronous active-high `rst` leaves the watch stopped with a count of 00.0. In that state `tenthsHot` is 10'b0000000001 and both segment outputs are 7'h3F.
- R2: A high-to-low change of `startStopN`, sampled at a clock edge, toggles running/stopped at that same edge. Holding the button low gives only that one toggle.
- R3: While stopped and not clearing, all three outputs hold their values.
- R4: `tenthsHot` always has exactly one bit set. Bit k set means tenths digit k. While running, the set bit moves from bit k to bit k+1 (bit 9 wraps to bit 0) once every `PRESCALE` clock cycles.
- R5: When tenths wraps from bit 9 to bit 0, the ones-seconds digit advances. When ones wraps from 9 to 0 at the same time, the tens-seconds digit advances.
- R6: The tick after 59.9 gives 00.0.
- R7: `clearReq` high at a clock edge while stopped sets the count to 00.0 and restarts the prescaler phase.
- R8: `clearReq` has no effect while the watch is running.
- R9: The segment outputs use bit order {g,f,e,d,c,b,a}, active high. Digits 0 to 9 map to 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| startStopN | input | 1 | Start/stop button, active low, already debounced |
| clearReq | input | 1 | Clear request, honoured only while stopped |
| tensSeg | output | 7 | Tens-seconds digit in seven-segment form |
| onesSeg | output | 7 | Ones-seconds digit in seven-segment form |
| tenthsHot | output | 10 | Tenths digit as a one-hot word |

## Verification
The assertions assume that `startStopN` and `clearReq` are clean, synchronous levels that change only between clock edges. They also assume that no press is shorter than one clock period, because the block does no debouncing. The bench changes both inputs only at the falling clock edge. Its random phase holds each press for one to several whole cycles and pulses clear for single cycles, in both the stopped and the running state.

// File: rtl/stopwatch_pkg.sv
package stopwatch_pkg;
  localparam int HOT_W     = 10;
  localparam int BCD_W     = 4;
  localparam int SEG_W     = 7;
  localparam int ONES_LAST = 9;
  localparam int TENS_LAST = 5;

  typedef struct packed {
    logic run;
    logic clear;
  } swStrobe_t;
endpackage

// File: rtl/stopwatch_ctrl.sv
module stopwatch_ctrl
  import stopwatch_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      startStopN,
  input  logic      clearReq,
  output swStrobe_t strb
);
  logic btnPrev;
  logic running;
  logic pressSeen;

  assign pressSeen = btnPrev & ~startStopN;

  always_ff @(posedge clk) begin
    if (rst) begin
      btnPrev <= 1'b1;
      running <= 1'b0;
    end else begin
      btnPrev <= startStopN;
      running <= running ^ pressSeen;
    end
  end

  always_comb begin
    strb.run   = running;
    strb.clear = ~running & clearReq;
  end

  // R2: a press flips the run state at the edge that sees it
  a_r2_press_toggles: assert property (@(posedge clk) disable iff (rst)
    (btnPrev && !startStopN) |=> (running != $past(running)));

  // R2: a held or released button leaves the run state alone
  a_r2_no_press_holds: assert property (@(posedge clk) disable iff (rst)
    !(btnPrev && !startStopN) |=> $stable(running));
endmodule

// File: rtl/stopwatch_seg.sv
module stopwatch_seg
  import stopwatch_pkg::*;
(
  input  logic [BCD_W-1:0] digit,
  output logic [SEG_W-1:0] seg
);
  always_comb begin
    case (digit)
      4'd0:    seg = 7'h3F;
      4'd1:    seg = 7'h06;
      4'd2:    seg = 7'h5B;
      4'd3:    seg = 7'h4F;
      4'd4:    seg = 7'h66;
      4'd5:    seg = 7'h6D;
      4'd6:    seg = 7'h7D;
      4'd7:    seg = 7'h07;
      4'd8:    seg = 7'h7F;
      4'd9:    seg = 7'h6F;
      default: seg = 7'h00;
    endcase
  end
endmodule

// File: rtl/stopwatch_datapath.sv
module stopwatch_datapath
  import stopwatch_pkg::*;
#(
  parameter int PRESCALE = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  swStrobe_t        strb,
  output logic [SEG_W-1:0] tensSeg,
  output logic [SEG_W-1:0] onesSeg,
  output logic [HOT_W-1:0] tenthsHot
);
  localparam int PRE_W = $clog2(PRESCALE + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);
  localparam logic [HOT_W-1:0] HOT_ZERO = HOT_W'(1);

  logic [PRE_W-1:0] preCnt;
  logic [HOT_W-1:0] tenthsReg;
  logic [BCD_W-1:0] onesReg;
  logic [BCD_W-1:0] tensReg;
  logic tickNow;
  logic wrapTenths;
  logic wrapOnes;

  assign tickNow    = strb.run && (preCnt == PRE_LAST);
  assign wrapTenths = tickNow && tenthsReg[HOT_W-1];
  assign wrapOnes   = wrapTenths && (onesReg == BCD_W'(ONES_LAST));

  always_ff @(posedge clk) begin
    if (rst || strb.clear) begin
      preCnt    <= '0;
      tenthsReg <= HOT_ZERO;
      onesReg   <= '0;
      tensReg   <= '0;
    end else if (strb.run) begin
      preCnt <= tickNow ? '0 : preCnt + 1'b1;
      if (tickNow)
        tenthsReg <= {tenthsReg[HOT_W-2:0], tenthsReg[HOT_W-1]};
      if (wrapTenths)
        onesReg <= wrapOnes ? '0 : onesReg + 1'b1;
      if (wrapOnes)
        tensReg <= (tensReg == BCD_W'(TENS_LAST)) ? '0 : tensReg + 1'b1;
    end
  end

  logic [1:0][BCD_W-1:0] digVal;
  logic [1:0][SEG_W-1:0] digSeg;
  assign digVal = {tensReg, onesReg};

  for (genvar g = 0; g < 2; g++) begin : g_seg
    stopwatch_seg u_seg (.digit(digVal[g]), .seg(digSeg[g]));
  end

  assign onesSeg   = digSeg[0];
  assign tensSeg   = digSeg[1];
  assign tenthsHot = tenthsReg;

  // R4: exactly one tenths bit is set
  a_r4_one_hot: assert property (@(posedge clk) disable iff (rst)
    $countones(tenthsReg) == 1);

  // R3: a stopped, non-clearing watch holds its count
  a_r3_hold_when_stopped: assert property (@(posedge clk) disable iff (rst)
    (!strb.run && !strb.clear) |=>
      ($stable(tenthsReg) && $stable(onesReg) && $stable(tensReg)));

  // R5: a tenths wrap below 9 seconds-ones bumps ones by one
  a_r5_ones_carry: assert property (@(posedge clk) disable iff (rst)
    (wrapTenths && onesReg != BCD_W'(ONES_LAST)) |=>
      (onesReg == $past(onesReg) + 1'b1) && tenthsReg[0]);

  // R6: the tick after 59.9 returns to 00.0
  a_r6_rollover: assert property (@(posedge clk) disable iff (rst)
    (wrapOnes && tensReg == BCD_W'(TENS_LAST)) |=>
      (tensReg == '0 && onesReg == '0 && tenthsReg == HOT_ZERO));

  // R7: a clear while stopped gives 00.0 one edge later
  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    strb.clear |=> (tensReg == '0 && onesReg == '0 && tenthsReg == HOT_ZERO));

  // R5: seconds digits stay inside their decimal ranges
  a_r5_bcd_range: assert property (@(posedge clk) disable iff (rst)
    (onesReg <= BCD_W'(ONES_LAST)) && (tensReg <= BCD_W'(TENS_LAST)));
endmodule

// File: rtl/stopwatch.sv
module stopwatch
  import stopwatch_pkg::*;
#(
  parameter int PRESCALE = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       startStopN,
  input  logic       clearReq,
  output logic [6:0] tensSeg,
  output logic [6:0] onesSeg,
  output logic [9:0] tenthsHot
);
  swStrobe_t strb;

  stopwatch_ctrl u_ctrl (
    .clk(clk), .rst(rst), .startStopN(startStopN), .clearReq(clearReq), .strb(strb)
  );

  stopwatch_datapath #(.PRESCALE(PRESCALE)) u_dp (
    .clk(clk), .rst(rst), .strb(strb),
    .tensSeg(tensSeg), .onesSeg(onesSeg), .tenthsHot(tenthsHot)
  );
endmodule

// File: tb/stopwatch_tb.sv
module stopwatch_tb;
  localparam int PRESCALE = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic startStopN = 1'b1;
  logic clearReq = 1'b0;
  logic [6:0] tensSeg, onesSeg;
  logic [9:0] tenthsHot;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int rollSeen = 0;

  // model state, built from the requirements
  bit mRun = 0, mPrev = 1;
  int mPre = 0, mIdx = 0, mOnes = 0, mTens = 0;

  always #5 clk = ~clk;

  stopwatch #(.PRESCALE(PRESCALE)) u_dut (
    .clk(clk), .rst(rst), .startStopN(startStopN), .clearReq(clearReq),
    .tensSeg(tensSeg), .onesSeg(onesSeg), .tenthsHot(tenthsHot)
  );

  function automatic logic [6:0] segOf(int d);
    case (d)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model, advanced at each rising edge
  always @(posedge clk) begin
    bit press, clr, tick;
    cycles++;
    if (rst) begin
      mRun = 0; mPrev = 1; mPre = 0; mIdx = 0; mOnes = 0; mTens = 0;
    end else begin
      press = mPrev && !startStopN;
      clr   = !mRun && clearReq;
      tick  = mRun && (mPre == PRESCALE - 1);
      if (clr) begin
        mPre = 0; mIdx = 0; mOnes = 0; mTens = 0;
      end else if (mRun) begin
        mPre = tick ? 0 : mPre + 1;
        if (tick) begin
          if (mIdx == 9) begin
            mIdx = 0;
            if (mOnes == 9) begin
              mOnes = 0;
              mTens = (mTens == 5) ? 0 : mTens + 1;
            end else mOnes++;
          end else mIdx++;
        end
      end
      mRun  = mRun ^ press;
      mPrev = startStopN;
    end
  end

  // cycle monitor, away from the active edge
  logic [9:0] lastHot = 10'h001;
  logic [6:0] lastOnes = 7'h3F, lastTens = 7'h3F;
  always @(negedge clk) begin
    if (!rst) begin
      check(tenthsHot == (10'h001 << mIdx), "R4 tenths position", tenthsHot, 10'h001 << mIdx);
      check($countones(tenthsHot) == 1, "R4 one-hot", tenthsHot, 1);
      check(onesSeg == segOf(mOnes), "R5 ones digit", onesSeg, segOf(mOnes));
      check(tensSeg == segOf(mTens), "R5 tens digit", tensSeg, segOf(mTens));
      if (lastHot == 10'h200 && lastOnes == 7'h6F && lastTens == 7'h6D && tenthsHot != lastHot) begin
        rollSeen++;
        check(tenthsHot == 10'h001 && onesSeg == 7'h3F && tensSeg == 7'h3F, "R6 rollover",
              {tensSeg, onesSeg, tenthsHot}, {7'h3F, 7'h3F, 10'h001});
      end
      lastHot = tenthsHot; lastOnes = onesSeg; lastTens = tensSeg;
    end
  end

  task automatic waitCyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic press(int holdCyc);
    startStopN = 1'b0;
    waitCyc(holdCyc);
    startStopN = 1'b1;
    waitCyc(1);
  endtask

  initial begin : watchdog
    wait (cycles > 190000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [9:0] hHot;
    logic [6:0] hOnes;
    void'($urandom(32'h5EED));
    waitCyc(3);
    rst = 1'b0;
    waitCyc(1);
    // R1 reset state
    check(tenthsHot == 10'h001, "R1 tenths after reset", tenthsHot, 10'h001);
    check(onesSeg == 7'h3F && tensSeg == 7'h3F, "R1 digits after reset", {tensSeg, onesSeg}, 14'h1FBF);
    // R9 digit 0 pattern
    check(onesSeg == 7'h3F, "R9 zero pattern", onesSeg, 7'h3F);

    // R2 start
    press(1);
    waitCyc(35);
    check(tenthsHot != 10'h001, "R2 start press begins counting", tenthsHot, 10'h001);

    // R3 stop and hold
    press(1);
    hHot = tenthsHot; hOnes = onesSeg;
    waitCyc(40);
    check(tenthsHot == hHot && onesSeg == hOnes, "R3 hold while stopped", tenthsHot, hHot);

    // R7 clear while stopped
    clearReq = 1'b1; waitCyc(1); clearReq = 1'b0;
    check(tenthsHot == 10'h001 && onesSeg == 7'h3F && tensSeg == 7'h3F, "R7 clear when stopped",
          tenthsHot, 10'h001);

    // R2 held button toggles once
    startStopN = 1'b0;
    waitCyc(300);
    hHot = tenthsHot;
    waitCyc(15);
    check(tenthsHot != hHot, "R2 long hold keeps running", tenthsHot, hHot);
    startStopN = 1'b1;
    waitCyc(20);
    // R8 clear while running ignored (about 3.3 s elapsed)
    clearReq = 1'b1; waitCyc(3); clearReq = 1'b0;
    check(onesSeg == 7'h4F, "R8 clear ignored while running", onesSeg, 7'h4F);
    // R9 digit 3 pattern
    check(onesSeg == 7'h4F, "R9 three pattern", onesSeg, 7'h4F);

    // R6 run through a full minute
    waitCyc(6200);
    check(rollSeen > 0, "R6 rollover observed", rollSeen, 1);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      if (r < 3) press($urandom_range(1, 6));
      else if (r < 8) begin
        clearReq = 1'b1; waitCyc(1); clearReq = 1'b0;
      end else waitCyc($urandom_range(1, 20));
    end

    // R6 second rollover from a clean start
    press(1);
    if (!mRun) press(1);
    waitCyc(6100);
    check(rollSeen > 1, "R6 second rollover", rollSeen, 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule